// File: doc/BRIEF.md
# Transfer Length Command Encoder

The block turns a requested byte count plus a command template into the shortest run of 20-bit sequencer entries that together move exactly that many bytes. Every bit of the count at position 8 or above becomes an exponent entry, which stands for 2^k bytes. Any nonzero low byte then becomes one immediate entry carrying that byte count.

A request is a 16-bit length, chip-select, bus and lane-width fields, transmit and receive flags, and a trailing flag. It is accepted through a valid/ready handshake. Entries leave one per cycle through a second valid/ready handshake. When the trailing flag is set, one all-zero no-op entry follows the data entries. The flag is meant for receive-only transfers that run under register control.

The encoder accepts a new request only after the downstream side has taken the last entry of the current one. Executing the entries and any register access are handled elsewhere.

Top module: `xfer_len_encoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A nonzero length below 256 produces exactly one data entry. Its exponent bit (bit 9) is 0 and its immediate field (bits 7:0) equals the length.
- R3: For each set bit k of the length with k >= 8, exactly one entry is produced with bit 9 set and immediate field k. Such an entry stands for 2^k bytes.
- R4: Exponent entries come out in strictly increasing order of k.
- R5: After the exponent entries, a nonzero low byte produces one final data entry with bit 9 clear and the low byte as its immediate field. A zero low byte produces no such entry.
- R6: Every data entry has bit 8 (data transfer) set. It also carries the template fields: lane mode in bits 11:10, chip select in 13:12, bus in 15:14, transmit in bit 16 and receive in bit 17. Bits 19:18 are 0.
- R7: When the trailing flag is set, exactly one all-zero entry follows the data entries.
- R8: A zero length produces no data entries. With the trailing flag clear it produces no entries at all, and `in_ready` stays 1.
- R9: `in_ready` is 0 from the cycle after a request is accepted until the last entry has been accepted downstream. It is 1 again in the cycle after that, with `out_valid` 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, the presented entry does not change and `out_valid` stays 1.
- R11: The sum of the byte counts implied by the emitted entries equals the requested length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Encoder can accept a request |
| in_len | input | 16 | Byte count |
| in_cs | input | 2 | Chip-select template field |
| in_bus | input | 2 | Bus template field |
| in_lanes | input | 2 | Lane-width template field |
| in_tx | input | 1 | Transmit template flag |
| in_rx | input | 1 | Receive template flag |
| in_trail | input | 1 | Append one all-zero entry |
| out_valid | output | 1 | Entry valid |
| out_ready | input | 1 | Downstream takes the entry |
| out_entry | output | 20 | Sequencer entry |

## Verification
Each entry is derived directly from registered state, so a wrong state shows up at the ports in the very next presented entry. A remaining-bit mask that drops or keeps a bit too long shows as a missing, duplicated or out-of-order exponent entry. It also breaks the byte total for that request. A pending flag for the low byte or the pad entry that is cleared or kept wrongly changes the entry count and moves the cycle in which `in_ready` returns. The sweep covers every length up to 1100, a stride across the full range, and the 255/256/257/65535 boundaries, all under irregular downstream stalls.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

    localparam int LEN_W   = 16;
    localparam int IMM_W   = 8;
    localparam int HI_W    = LEN_W - IMM_W;
    localparam int IDX_W   = $clog2(HI_W);
    localparam int ENTRY_W = 20;

    // entry field positions, decoded by the sequencer downstream
    localparam int POS_DATA  = 8;
    localparam int POS_EXP   = 9;
    localparam int POS_LANES = 10;
    localparam int POS_CS    = 12;
    localparam int POS_BUS   = 14;
    localparam int POS_TX    = 16;
    localparam int POS_RX    = 17;

    typedef struct packed {
        logic [1:0] bus;
        logic [1:0] cs;
        logic [1:0] lanes;
        logic       tx;
        logic       rx;
    } lenc_tmpl_t;

    typedef enum logic [1:0] {
        KIND_EXP = 2'd0,
        KIND_IMM = 2'd1,
        KIND_PAD = 2'd2
    } lenc_kind_t;

    function automatic logic [ENTRY_W-1:0] build_entry(
        input lenc_tmpl_t       t,
        input logic             is_exp,
        input logic [IMM_W-1:0] imm
    );
        logic [ENTRY_W-1:0] e;
        e                          = '0;
        e[IMM_W-1:0]               = imm;
        e[POS_DATA]                = 1'b1;
        e[POS_EXP]                 = is_exp;
        e[POS_LANES+1:POS_LANES]   = t.lanes;
        e[POS_CS+1:POS_CS]         = t.cs;
        e[POS_BUS+1:POS_BUS]       = t.bus;
        e[POS_TX]                  = t.tx;
        e[POS_RX]                  = t.rx;
        return e;
    endfunction

endpackage

// File: rtl/lenc_lowbit.sv
module lenc_lowbit #(
    parameter int W   = 8,
    parameter int IW  = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [W-1:0]  onehot,
    output logic [IW-1:0] idx
);
    logic [W:0] below;

    assign below[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_chain
            assign below[i+1] = below[i] | vec[i];
            assign onehot[i]  = vec[i] & ~below[i];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int k = 0; k < W; k++) begin
            if (onehot[k]) idx = idx | IW'(k);
        end
    end
endmodule

// File: rtl/lenc_fmt.sv
module lenc_fmt
    import lenc_pkg::*;
(
    input  lenc_tmpl_t         tmpl,
    input  lenc_kind_t         kind,
    input  logic [IDX_W-1:0]   exp_idx,
    input  logic [IMM_W-1:0]   low,
    output logic [ENTRY_W-1:0] entry
);
    logic [IMM_W-1:0] exp_imm;

    assign exp_imm = IMM_W'(IMM_W) + IMM_W'(exp_idx);

    always_comb begin
        unique case (kind)
            KIND_EXP: entry = build_entry(tmpl, 1'b1, exp_imm);
            KIND_IMM: entry = build_entry(tmpl, 1'b0, low);
            default:  entry = '0;
        endcase
    end
endmodule

// File: rtl/xfer_len_encoder.sv
module xfer_len_encoder
    import lenc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LEN_W-1:0]   in_len,
    input  logic [1:0]         in_cs,
    input  logic [1:0]         in_bus,
    input  logic [1:0]         in_lanes,
    input  logic               in_tx,
    input  logic               in_rx,
    input  logic               in_trail,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ENTRY_W-1:0] out_entry
);
    logic [HI_W-1:0]  hi_rem_q;
    logic [IMM_W-1:0] low_q;
    logic             low_pend_q;
    logic             pad_pend_q;
    lenc_tmpl_t       tmpl_q;

    logic [HI_W-1:0]  pick_onehot;
    logic [IDX_W-1:0] pick_idx;
    lenc_kind_t       kind;
    logic             busy;
    logic             fire_in;
    logic             fire_out;

    lenc_lowbit #(.W(HI_W), .IW(IDX_W)) u_pick (
        .vec    (hi_rem_q),
        .onehot (pick_onehot),
        .idx    (pick_idx)
    );

    always_comb begin
        if (|hi_rem_q)      kind = KIND_EXP;
        else if (low_pend_q) kind = KIND_IMM;
        else                 kind = KIND_PAD;
    end

    lenc_fmt u_fmt (
        .tmpl    (tmpl_q),
        .kind    (kind),
        .exp_idx (pick_idx),
        .low     (low_q),
        .entry   (out_entry)
    );

    assign busy      = (|hi_rem_q) | low_pend_q | pad_pend_q;
    assign in_ready  = ~busy;
    assign out_valid = busy;
    assign fire_in   = in_valid & in_ready;
    assign fire_out  = out_valid & out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_rem_q   <= '0;
            low_q      <= '0;
            low_pend_q <= 1'b0;
            pad_pend_q <= 1'b0;
            tmpl_q     <= '0;
        end else if (fire_in) begin
            hi_rem_q   <= in_len[LEN_W-1:IMM_W];
            low_q      <= in_len[IMM_W-1:0];
            low_pend_q <= |in_len[IMM_W-1:0];
            pad_pend_q <= in_trail;
            tmpl_q     <= '{bus: in_bus, cs: in_cs, lanes: in_lanes,
                            tx: in_tx, rx: in_rx};
        end else if (fire_out) begin
            unique case (kind)
                KIND_EXP: hi_rem_q   <= hi_rem_q & ~pick_onehot;
                KIND_IMM: low_pend_q <= 1'b0;
                default:  pad_pend_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lenc_checker.sv
module lenc_checker
    import lenc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [ENTRY_W-1:0] out_entry
);
    logic             seen_exp;
    logic [IMM_W-1:0] last_exp;

    always_ff @(posedge clk) begin
        if (rst || (in_valid && in_ready)) begin
            seen_exp <= 1'b0;
            last_exp <= '0;
        end else if (out_valid && out_ready && out_entry[POS_EXP]) begin
            seen_exp <= 1'b1;
            last_exp <= out_entry[IMM_W-1:0];
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_entry));

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    assert_data_bit_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_entry != '0) |-> out_entry[POS_DATA] && (out_entry[ENTRY_W-1:ENTRY_W-2] == 2'b00));

    assert_exp_range_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_entry[POS_EXP] |-> (out_entry[IMM_W-1:0] >= IMM_W) && (out_entry[IMM_W-1:0] < LEN_W));

    assert_exp_order_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_entry[POS_EXP] && seen_exp |-> out_entry[IMM_W-1:0] > last_exp);

    assert_pad_last_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && (out_entry == '0) |=> in_ready);
endmodule

bind xfer_len_encoder lenc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_entry (out_entry)
);

// File: tb/xfer_len_encoder_test.sv
`timescale 1ns/1ps
module xfer_len_encoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_len;
    logic [1:0]  in_cs, in_bus, in_lanes;
    logic        in_tx, in_rx, in_trail;
    logic        out_valid;
    logic        out_ready;
    logic [19:0] out_entry;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    xfer_len_encoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_len(in_len), .in_cs(in_cs), .in_bus(in_bus), .in_lanes(in_lanes),
        .in_tx(in_tx), .in_rx(in_rx), .in_trail(in_trail),
        .out_valid(out_valid), .out_ready(out_ready), .out_entry(out_entry)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected entry layout from R6
    function automatic logic [19:0] mk(input logic [7:0] t, input bit e, input logic [7:0] imm);
        return {2'b00, t[0], t[1], t[7:6], t[5:4], t[3:2], e, 1'b1, imm};
    endfunction

    task automatic run(input int len, input logic [7:0] t, input bit trail, input int seed);
        logic [19:0] ex[0:15];
        int          n = 0;
        int          got = 0;
        int          cyc = 0;
        longint      sum = 0;
        bit          held = 0;
        logic [19:0] held_e = '0;
        for (int k = 8; k < 16; k++)
            if (len[k]) begin ex[n] = mk(t, 1'b1, 8'(k)); n++; end
        if ((len & 255) != 0) begin ex[n] = mk(t, 1'b0, 8'(len & 255)); n++; end
        if (trail) begin ex[n] = '0; n++; end

        @(negedge clk);
        in_len = 16'(len); in_bus = t[7:6]; in_cs = t[5:4]; in_lanes = t[3:2];
        in_tx = t[1]; in_rx = t[0]; in_trail = trail; in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (got < n && cyc < 64) begin
            bit rdy = ((cyc + seed) % 3) != 2;
            string tag;
            out_ready = rdy;
            if (ex[got] == '0) tag = "R7";
            else if (ex[got][9]) tag = "R3";
            else if (len < 256) tag = "R2";
            else tag = "R5";
            check(out_valid === 1'b1 && out_entry === ex[got], tag, out_entry, ex[got]);
            check(in_ready === 1'b0, "R9", in_ready, 0);
            if (held) check(out_entry === held_e, "R10", out_entry, held_e);
            if (rdy) begin
                if (out_entry[9]) sum += longint'(1) << out_entry[7:0];
                else sum += out_entry[7:0];
                got++;
                held = 0;
            end else begin
                held = 1;
                held_e = out_entry;
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        check(out_valid === 1'b0 && in_ready === 1'b1, (len == 0) ? "R8" : "R9",
              {out_valid, in_ready}, 2'b01);
        check(sum == longint'(len), "R11", sum, len);
    endtask

    initial begin
        rst = 1'b1; in_valid = 0; in_len = 0; in_cs = 0; in_bus = 0; in_lanes = 0;
        in_tx = 0; in_rx = 0; in_trail = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1", {out_valid, in_ready}, 2'b01);
        rst = 1'b0;
        // R6 template fields vary with each request
        for (int l = 0; l <= 1100; l++) run(l, 8'(l * 37), (l % 5) == 0, l);
        for (int l = 1101; l < 65536; l += 89) run(l, 8'(l * 11), (l % 3) == 0, l);
        for (int b = 0; b < 2; b++) begin
            run(255, 8'hA5, b[0], 1);
            run(256, 8'h5A, b[0], 2);
            run(257, 8'hFF, b[0], 0);
            run(65535, 8'h3C, b[0], 1);
            run(65280, 8'hC3, b[0], 2);
            run(32768, 8'h81, b[0], 0);
            run(0, 8'h42, b[0], 1);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule